// File: doc/BRIEF.md
# Carry-Free Signed-Digit Plus Binary Adder

This block adds an N-digit radix-2 signed-digit operand, in which every digit is -1, 0 or +1, to an N-bit unsigned binary operand. It returns an (N+1)-digit signed-digit sum without any carry ripple. Each position splits its signed digit and binary bit into a carry bit (0 or 1) and a primary digit (0 or -1). Each output digit then merges the carry coming up from the position below with the local primary digit. The logic depth is the same at every width.

The sum uses the same digit code as the signed-digit input, so it can be fed straight back as the signed-digit operand of a following addition. That lets a chain of these adders accumulate any number of binary words. The result is registered once. The block flags any input digit that carries the unused code and treats that digit as zero.

Top module: `sd_bin_adder`

## Requirements
- R1: While `rst_n` is low, `sum_q` is all zero digits and `code_err_q` is 0.
- R2: Inputs sampled at a rising clock edge appear on `sum_q` and `code_err_q` after that edge and remain unchanged until the next edge.
- R3: The signed value of `sum_q`, which is the sum of digit_i times 2^i, equals the value of `sd_a` plus the value of `bin_b`.
- R4: Carry split per position: a -1 digit gives carry 0, a 0 digit gives carry equal to the binary bit, and a +1 digit gives carry 1. With only position 0 non-zero, sum digit 1 shows this carry.
- R5: Primary split per position: the result is -1 when exactly one of "digit is non-zero" and "bit is 1" holds, and 0 otherwise. With only position 0 non-zero, sum digit 0 shows this primary.
- R6: Merge: carry 0 with primary 0 gives 0, carry 1 with primary 0 gives +1, carry 0 with primary -1 gives -1, and carry 1 with primary -1 gives 0. No output digit ever takes the code 11.
- R7: The top sum digit is never -1, and the lowest sum digit is never +1.
- R8: Digit code {hi,lo}: +1 = 10, 0 = 00, -1 = 01. Code 11 on any `sd_a` digit sets `code_err_q` for that result, and that digit is added as 0.
- R9: The signed-digit operand "+1,-1" (value 1) plus binary 10 (value 2) gives the digits "0,+1,0,-1" at N = 3, which has the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_a | input | 2*N | Signed-digit operand, digit i at bits [2i+1:2i] |
| bin_b | input | N | Unsigned binary operand |
| sum_q | output | 2*(N+1) | Registered signed-digit sum, digit i at bits [2i+1:2i] |
| code_err_q | output | 1 | Registered flag: an input digit carried code 11 |

## Verification
The hardest case to reach is the merge of carry 1 with primary -1, because it needs two neighbouring positions set up together. The lower position must emit a carry, and the upper one must produce a -1 primary. Exhaustive sweeps at N = 2 and N = 3 cover every such pairing, including digits carrying code 11. Single-position vectors with all other positions zero expose the carry and primary splits directly on output digits 1 and 0.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;
    typedef logic [1:0] sd_code_t;
    localparam sd_code_t SD_ZERO = 2'b00;
    localparam sd_code_t SD_NEG  = 2'b01;
    localparam sd_code_t SD_POS  = 2'b10;
    localparam sd_code_t SD_BAD  = 2'b11;

    function automatic int sd_code_val(input sd_code_t c);
        case (c)
            SD_POS:  return 1;
            SD_NEG:  return -1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/sd_digit_split.sv
module sd_digit_split
    import sdadd_pkg::*;
(
    input  sd_code_t sd_code,
    input  logic     bin_bit,
    output logic     carry_bit,
    output sd_code_t prim_code,
    output logic     illegal
);
    logic is_pos;
    logic is_neg;

    always_comb begin
        is_pos    = (sd_code == SD_POS);
        is_neg    = (sd_code == SD_NEG);
        illegal   = (sd_code == SD_BAD);
        carry_bit = is_pos | (~is_pos & ~is_neg & bin_bit);
        prim_code = ((is_pos | is_neg) ^ bin_bit) ? SD_NEG : SD_ZERO;
    end

    always_comb begin
        AST_DIGIT_BALANCE: assert (2 * int'(carry_bit) + sd_code_val(prim_code)
                                   == sd_code_val(sd_code) + int'(bin_bit)); // R3
    end
endmodule

// File: rtl/sd_digit_merge.sv
module sd_digit_merge
    import sdadd_pkg::*;
(
    input  logic     carry_in,
    input  sd_code_t prim_code,
    output sd_code_t sum_code
);
    logic prim_neg;

    always_comb begin
        prim_neg = (prim_code == SD_NEG);
        if (carry_in && !prim_neg)
            sum_code = SD_POS;
        else if (!carry_in && prim_neg)
            sum_code = SD_NEG;
        else
            sum_code = SD_ZERO;
    end

    always_comb begin
        AST_MERGE_LEGAL: assert (sum_code != SD_BAD); // R6
    end
endmodule

// File: rtl/sd_bin_adder.sv
module sd_bin_adder
    import sdadd_pkg::*;
#(
    parameter int N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*N-1:0]   sd_a,
    input  logic [N-1:0]     bin_b,
    output logic [2*N+1:0]   sum_q,
    output logic             code_err_q
);
    localparam int OUT_DIGITS = N + 1;
    localparam int OUT_W      = 2 * OUT_DIGITS;

    typedef struct packed {
        logic [OUT_W-1:0] sum;
        logic             err;
    } state_t;

    state_t state_d, state_q;

    logic [N-1:0]     carry_vec;
    logic [2*N-1:0]   prim_vec;
    logic [N-1:0]     illegal_vec;
    logic [OUT_W-1:0] merged_vec;

    for (genvar i = 0; i < N; i++) begin : g_split
        sd_digit_split u_split (
            .sd_code   (sd_a[2*i +: 2]),
            .bin_bit   (bin_b[i]),
            .carry_bit (carry_vec[i]),
            .prim_code (prim_vec[2*i +: 2]),
            .illegal   (illegal_vec[i])
        );
    end

    for (genvar i = 0; i < OUT_DIGITS; i++) begin : g_merge
        logic     cin;
        sd_code_t prim;
        if (i == 0) begin : g_low
            assign cin = 1'b0;
        end else begin : g_mid
            assign cin = carry_vec[i-1];
        end
        if (i == N) begin : g_top
            assign prim = SD_ZERO;
        end else begin : g_body
            assign prim = prim_vec[2*i +: 2];
        end
        sd_digit_merge u_merge (
            .carry_in  (cin),
            .prim_code (prim),
            .sum_code  (merged_vec[2*i +: 2])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.sum = merged_vec;
        state_d.err = |illegal_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign sum_q      = state_q.sum;
    assign code_err_q = state_q.err;

    function automatic int digits_value(input logic [OUT_W-1:0] v);
        int acc = 0;
        for (int k = OUT_DIGITS - 1; k >= 0; k--)
            acc = 2 * acc + sd_code_val(v[2*k +: 2]);
        return acc;
    endfunction

    function automatic int bad_digits(input logic [OUT_W-1:0] v);
        int cnt = 0;
        for (int k = 0; k < OUT_DIGITS; k++)
            if (v[2*k +: 2] == SD_BAD) cnt++;
        return cnt;
    endfunction

    int in_value;
    always_comb begin
        in_value = digits_value({2'b00, sd_a}) + int'(bin_b);
    end

    AST_SUM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (digits_value(sum_q) == $past(in_value))); // R3

    AST_ERR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (code_err_q == $past(|illegal_vec))); // R8

    AST_TOP_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q[OUT_W-1 -: 2] != SD_NEG); // R7

    AST_LOW_NOPOS: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q[1:0] != SD_POS); // R7

    AST_OUT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bad_digits(sum_q) == 0); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (sum_q == '0 && !code_err_q)); // R1
endmodule

// File: tb/sd_bin_adder_tb.sv
module sd_bin_adder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] a3 = '0;
    logic [2:0] b3 = '0;
    logic [3:0] a2 = '0;
    logic [1:0] b2 = '0;
    logic [7:0] s3;
    logic [5:0] s2;
    logic e3, e2;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sd_bin_adder #(.N(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .sd_a(a3), .bin_b(b3),
        .sum_q(s3), .code_err_q(e3));

    sd_bin_adder #(.N(2)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .sd_a(a2), .bin_b(b2),
        .sum_q(s2), .code_err_q(e2));

    // {sd_a, bin_b, expected sum, expected err}
    typedef struct packed {
        logic [5:0] a;
        logic [2:0] b;
        logic [7:0] s;
        logic       e;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'b000001, 3'b000, 8'b00000001, 1'b0},  // R4 R5 (-1,0)
        '{6'b000000, 3'b000, 8'b00000000, 1'b0},  // R4 R5 (0,0)
        '{6'b000010, 3'b000, 8'b00001001, 1'b0},  // R4 R5 (+1,0)
        '{6'b000001, 3'b001, 8'b00000000, 1'b0},  // R4 R5 (-1,1)
        '{6'b000000, 3'b001, 8'b00001001, 1'b0},  // R4 R5 (0,1)
        '{6'b000010, 3'b001, 8'b00001000, 1'b0},  // R4 R5 (+1,1)
        '{6'b001001, 3'b010, 8'b00100001, 1'b0},  // R9 example
        '{6'b000010, 3'b010, 8'b00100001, 1'b0},  // R6 carry 1 with primary -1
        '{6'b001100, 3'b000, 8'b00000000, 1'b1}   // R8 illegal digit
    };

    function automatic int dval(input logic [15:0] v, input int nd);
        int acc = 0;
        for (int k = nd - 1; k >= 0; k--) begin
            acc = acc * 2;
            if (v[2*k +: 2] == 2'b10) acc = acc + 1;
            else if (v[2*k +: 2] == 2'b01) acc = acc - 1;
        end
        return acc;
    endfunction

    function automatic bit has_bad(input logic [15:0] v, input int nd);
        for (int k = 0; k < nd; k++)
            if (v[2*k +: 2] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic edge_digits3(input logic [7:0] s);
        chk(s[7:6] != 2'b01, "R7 top", s[7:6], 0);
        chk(s[1:0] != 2'b10, "R7 low", s[1:0], 0);
        for (int k = 0; k < 4; k++)
            chk(s[2*k +: 2] != 2'b11, "R6 legal", s[2*k +: 2], 0);
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        a3 = 6'b101010; b3 = 3'b111; a2 = 4'b1111; b2 = 2'b11;
        repeat (3) @(negedge clk);
        chk(s3 == '0, "R1 sum3", s3, 0);
        chk(e3 == 1'b0, "R1 err3", e3, 0);
        chk(s2 == '0, "R1 sum2", s2, 0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a3 = VECS[i].a; b3 = VECS[i].b;
            @(negedge clk);
            chk(s3 == VECS[i].s, "R4 R5 R6 R9 vector", s3, VECS[i].s);
            chk(e3 == VECS[i].e, "R8 vector err", e3, VECS[i].e);
        end

        // R2: output holds until next edge
        @(negedge clk);
        a3 = 6'b000010; b3 = 3'b000;
        @(negedge clk);
        a3 = 6'b000000; b3 = 3'b001;
        #1;
        chk(s3 == 8'b00001001, "R2 hold", s3, 8'b00001001);
        @(negedge clk);
        chk(s3 == 8'b00001001, "R2 update", s3, 8'b00001001);

        // R3 R8: exhaustive N=3
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                a3 = a[5:0]; b3 = b[2:0];
                @(negedge clk);
                chk(dval({8'b0, s3}, 4) == dval({10'b0, a[5:0]}, 3) + b,
                    "R3 value n3", dval({8'b0, s3}, 4), dval({10'b0, a[5:0]}, 3) + b);
                chk(e3 == has_bad({10'b0, a[5:0]}, 3), "R8 err n3", e3,
                    has_bad({10'b0, a[5:0]}, 3));
                edge_digits3(s3);
            end
        end

        // R3 R8: exhaustive N=2
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                a2 = a[3:0]; b2 = b[1:0];
                @(negedge clk);
                chk(dval({10'b0, s2}, 3) == dval({12'b0, a[3:0]}, 2) + b,
                    "R3 value n2", dval({10'b0, s2}, 3), dval({12'b0, a[3:0]}, 2) + b);
                chk(e2 == has_bad({12'b0, a[3:0]}, 2), "R8 err n2", e2,
                    has_bad({12'b0, a[3:0]}, 2));
                chk(s2[5:4] != 2'b01, "R7 top n2", s2[5:4], 0);
            end
        end

        // R1: reset mid-run clears output
        @(negedge clk);
        a3 = 6'b111111; b3 = 3'b111;
        @(negedge clk);
        chk(e3 == 1'b1, "R8 all bad", e3, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(s3 == '0 && e3 == 1'b0, "R1 mid reset", {e3, s3}, 0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule